// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block joins two 18-bit buses, side A and side B, with one independent storage path in each direction. For each direction a latch-enable and a capture clock select one of three behaviours. The path can follow its source bus, hold its last value, or take a new value on a rising edge of the capture clock. Each direction's output has its own enable. The A-to-B enable is active high and the B-to-A enable is active low. Bidirectional pins appear as an input data word, an output data word and an output-enable per side, so a pad ring or tristate wrapper can be added outside.

Every input bit has a valid flag. A bit whose flag is low counts as floating, and a per-bit keeper then supplies the last level seen on that bit while it was driven. The whole block runs from one system clock. The capture clocks and latch-enables are sampled on that clock, so transparent mode appears one system cycle later. An active-low reset clears both storage paths and all keepers and turns both output enables off at once. Its release is synchronised, so normal operation resumes on the system clock.

Top module: `dual_latch_xcvr`

## Requirements
- R1: Data travels unchanged (non-inverted) through a path of width W (default 18); all-ones, all-zeros and alternating patterns arrive bit for bit.
- R2: While `ab_le` is 1, `b_dout` equals the effective A input sampled at the previous system clock edge (transparent mode).
- R3: While `ab_le` is 0 and `ab_cp` does not rise between two system edges (steady high, steady low or falling), `b_dout` keeps its value whatever `a_din` does.
- R4: While `ab_le` is 0, a 0-to-1 change of `ab_cp` seen at a system edge loads the effective A input into the A-to-B path at that edge.
- R5: `b_oe` is 1 exactly when `ab_oe` is 1 (active high) outside reset.
- R6: The B-to-A path follows, holds and captures in the same way, controlled only by `ba_le` and `ba_cp`, and drives `a_dout`.
- R7: `a_oe` is 1 exactly when `ba_oe_n` is 0 (active low) outside reset.
- R8: For each bit whose valid flag is 0, the path sees the last value that bit carried while its flag was 1 (0 if never driven since reset), and the present data bit is ignored.
- R9: While `rst_n` is 0, both outputs read 0 and both output enables are 0, at once and regardless of the control inputs.
- R10: After `rst_n` rises, output enables stay 0 for the first system edge and follow their controls from the second edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all controls |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| a_din | input | 18 | Data arriving on side A |
| a_din_vld | input | 18 | Per-bit flag: side A bit is driven |
| a_dout | output | 18 | Data to drive onto side A |
| a_oe | output | 1 | Side A drive enable |
| b_din | input | 18 | Data arriving on side B |
| b_din_vld | input | 18 | Per-bit flag: side B bit is driven |
| b_dout | output | 18 | Data to drive onto side B |
| b_oe | output | 1 | Side B drive enable |
| ab_le | input | 1 | A-to-B transparent select |
| ab_cp | input | 1 | A-to-B capture clock, rising edge |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A transparent select |
| ba_cp | input | 1 | B-to-A capture clock, rising edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
Each direction is driven through follow, hold and capture runs with all-ones, all-zeros, alternating and single-bit words. That separates a path that tracks its input from one that freezes it or inverts bits. Hold runs change the data while the capture clock stays high and then falls, which exposes a path that triggers on the wrong edge or on a level. Partial valid masks followed by fully floating inputs show whether keepers retain the last driven bits instead of the live data. Resets asserted both at start and mid-run, with every enable requested, show that the enables and storage clear, and that the enables return only on the second edge after release.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_FOLLOW  = 2'd1,
    MODE_CAPTURE = 2'd2
  } store_mode_e;

  localparam int unsigned RST_STAGES = 2;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/xcvr_bus_keeper.sv
module xcvr_bus_keeper #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_d,
  input  logic [W-1:0] pin_vld,
  output logic [W-1:0] eff_d
);
  logic [W-1:0] keep_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          keep_q[i] <= 1'b0;
      else if (pin_vld[i]) keep_q[i] <= pin_d[i];
    end
    assign eff_d[i] = pin_vld[i] ? pin_d[i] : keep_q[i];
  end
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic         le,
  input  logic         cp,
  output logic [W-1:0] q
);
  logic         cp_prev_q;
  logic         cp_rise;
  logic         load_en;
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;
  store_mode_e  mode;

  always_comb begin
    cp_rise = cp & ~cp_prev_q;
    if (le)           mode = MODE_FOLLOW;
    else if (cp_rise) mode = MODE_CAPTURE;
    else              mode = MODE_HOLD;
    load_en = (mode != MODE_HOLD);
    q_d     = load_en ? d : q_q;
  end

  // capture clock history resets high: a clock already high at release
  // does not count as a rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_prev_q <= 1'b1;
      q_q       <= '0;
    end else begin
      cp_prev_q <= cp;
      if (load_en) q_q <= q_d;
    end
  end

  assign q = q_q;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int unsigned W             = 18,
  parameter bit          OE_ACTIVE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] din_vld,
  input  logic         le,
  input  logic         cp,
  input  logic         oe_ctl,
  output logic [W-1:0] dout,
  output logic         oe
);
  logic [W-1:0] eff_d;
  logic         oe_req;

  xcvr_bus_keeper #(.W(W)) u_keep (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_d   (din),
    .pin_vld (din_vld),
    .eff_d   (eff_d)
  );

  xcvr_store #(.W(W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (eff_d),
    .le    (le),
    .cp    (cp),
    .q     (dout)
  );

  if (OE_ACTIVE_LOW) begin : g_oe_low
    assign oe_req = ~oe_ctl;
  end else begin : g_oe_high
    assign oe_req = oe_ctl;
  end

  assign oe = oe_req & rst_n;
endmodule

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] a_din_vld,
  output logic [W-1:0] a_dout,
  output logic         a_oe,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] b_din_vld,
  output logic [W-1:0] b_dout,
  output logic         b_oe,
  input  logic         ab_le,
  input  logic         ab_cp,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_cp,
  input  logic         ba_oe_n
);
  logic rst_s_n;

  xcvr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  xcvr_lane #(.W(W), .OE_ACTIVE_LOW(1'b0)) u_ab (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .din     (a_din),
    .din_vld (a_din_vld),
    .le      (ab_le),
    .cp      (ab_cp),
    .oe_ctl  (ab_oe),
    .dout    (b_dout),
    .oe      (b_oe)
  );

  xcvr_lane #(.W(W), .OE_ACTIVE_LOW(1'b1)) u_ba (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .din     (b_din),
    .din_vld (b_din_vld),
    .le      (ba_le),
    .cp      (ba_cp),
    .oe_ctl  (ba_oe_n),
    .dout    (a_dout),
    .oe      (a_oe)
  );
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_din,
  input logic [W-1:0] a_din_vld,
  input logic [W-1:0] a_dout,
  input logic         a_oe,
  input logic [W-1:0] b_din,
  input logic [W-1:0] b_din_vld,
  input logic [W-1:0] b_dout,
  input logic         b_oe,
  input logic         ab_le,
  input logic         ab_cp,
  input logic         ab_oe,
  input logic         ba_le,
  input logic         ba_cp,
  input logic         ba_oe_n
);
  logic [1:0] live_cnt;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                live_cnt <= 2'd0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end
  assign live = (live_cnt == 2'd3);

  always @(posedge clk) begin
    if (!rst_n) AST_RST_OE_OFF: assert (!a_oe && !b_oe); // R9
  end

  AST_AB_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    live && ab_le && (&a_din_vld) |=> b_dout == $past(a_din)); // R2
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    live && !ab_le && !$rose(ab_cp) |=> $stable(b_dout)); // R3
  AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    live && !ba_le && $rose(ba_cp) && (&b_din_vld) |=> a_dout == $past(b_din)); // R6
  AST_B_OE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    b_oe |-> ab_oe); // R5
  AST_B_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    live && ab_oe |-> b_oe); // R5
  AST_A_OE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe |-> !ba_oe_n); // R7
endmodule

bind dual_latch_xcvr xcvr_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_din     (a_din),
  .a_din_vld (a_din_vld),
  .a_dout    (a_dout),
  .a_oe      (a_oe),
  .b_din     (b_din),
  .b_din_vld (b_din_vld),
  .b_dout    (b_dout),
  .b_oe      (b_oe),
  .ab_le     (ab_le),
  .ab_cp     (ab_cp),
  .ab_oe     (ab_oe),
  .ba_le     (ba_le),
  .ba_cp     (ba_cp),
  .ba_oe_n   (ba_oe_n)
);

// File: tb/sim_dual_latch_xcvr.sv
module sim_dual_latch_xcvr;
  localparam int W = 18;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_din, a_din_vld, a_dout, b_din, b_din_vld, b_dout;
  logic         a_oe, b_oe, ab_le, ab_cp, ab_oe, ba_le, ba_cp, ba_oe_n;

  int total = 0;
  int bad   = 0;

  // reference state derived from the requirements
  logic [W-1:0] m_keep_ab, m_q_ab, m_keep_ba, m_q_ba;
  logic         m_cp_ab, m_cp_ba;

  logic [W-1:0] exp_a_q[$];
  logic [W-1:0] exp_b_q[$];
  logic         exp_aoe_q[$];
  logic         exp_boe_q[$];
  string        tag_q[$];

  dual_latch_xcvr #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_din(a_din), .a_din_vld(a_din_vld), .a_dout(a_dout), .a_oe(a_oe),
    .b_din(b_din), .b_din_vld(b_din_vld), .b_dout(b_dout), .b_oe(b_oe),
    .ab_le(ab_le), .ab_cp(ab_cp), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_cp(ba_cp), .ba_oe_n(ba_oe_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string fld,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, fld, act, exp);
    end
  endtask

  // driver: inputs already set at a falling edge; predict and queue
  task automatic step(input string tag);
    logic [W-1:0] eff;
    eff = (a_din & a_din_vld) | (m_keep_ab & ~a_din_vld);
    if (ab_le || (ab_cp && !m_cp_ab)) m_q_ab = eff;
    m_keep_ab = eff;
    m_cp_ab   = ab_cp;
    eff = (b_din & b_din_vld) | (m_keep_ba & ~b_din_vld);
    if (ba_le || (ba_cp && !m_cp_ba)) m_q_ba = eff;
    m_keep_ba = eff;
    m_cp_ba   = ba_cp;
    exp_b_q.push_back(m_q_ab);
    exp_boe_q.push_back(ab_oe);
    exp_a_q.push_back(m_q_ba);
    exp_aoe_q.push_back(!ba_oe_n);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (tag_q.size() > 0) begin
        logic [W-1:0] ea, eb;
        logic eao, ebo;
        string t;
        ea = exp_a_q.pop_front(); eb = exp_b_q.pop_front();
        eao = exp_aoe_q.pop_front(); ebo = exp_boe_q.pop_front();
        t = tag_q.pop_front();
        chk(b_dout === eb, t, "b_dout", b_dout, eb);
        chk(b_oe === ebo, t, "b_oe", W'(b_oe), W'(ebo));
        chk(a_dout === ea, t, "a_dout", a_dout, ea);
        chk(a_oe === eao, t, "a_oe", W'(a_oe), W'(eao));
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    ab_oe = 1'b1; ba_oe_n = 1'b0; ab_le = 1'b0; ab_cp = 1'b0;
    ba_le = 1'b0; ba_cp = 1'b0;
    a_din = 18'h2B3C1; b_din = 18'h1D0E7; a_din_vld = '0; b_din_vld = '0;
    #1;
    chk(a_dout === '0 && b_dout === '0, "R9", "dout immediate", a_dout | b_dout, '0);
    chk(!a_oe && !b_oe, "R9", "oe immediate", W'({a_oe, b_oe}), '0);
    @(negedge clk); @(negedge clk);
    chk(!a_oe && !b_oe, "R9", "oe held", W'({a_oe, b_oe}), '0);
    rst_n = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    chk(!a_oe && !b_oe, "R10", "oe first edge", W'({a_oe, b_oe}), '0);
    @(posedge clk); #(CLK_PERIOD/4);
    chk(a_oe && b_oe, "R10", "oe second edge", W'({a_oe, b_oe}), W'(2'b11));
    @(negedge clk);
    m_keep_ab = '0; m_q_ab = '0; m_cp_ab = 1'b0;
    m_keep_ba = '0; m_q_ba = '0; m_cp_ba = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    a_din_vld = ONES; b_din_vld = ONES;

    // R2 / R1: A-to-B transparent with several patterns
    ab_le = 1'b1; a_din = ONES;        step("R1 ones");
    a_din = 18'h2AAAA;                 step("R1 alt");
    a_din = 18'h15555;                 step("R2 follow");
    a_din = 18'h00001;                 step("R2 follow");
    // R3: hold with clock low, data changing
    ab_le = 1'b0; a_din = 18'h3C3C3;   step("R3 hold low");
    a_din = 18'h00000;                 step("R3 hold low");
    // R4: rising capture clock
    ab_cp = 1'b1; a_din = 18'h12345;   step("R4 capture");
    a_din = 18'h3FFF0;                 step("R3 hold high");
    ab_cp = 1'b0; a_din = 18'h0F0F0;   step("R3 falling edge");
    ab_cp = 1'b1;                      step("R4 capture again");
    ab_cp = 1'b0; a_din = '0;          step("R3 falling edge");
    // R5: A-to-B enable polarity
    ab_oe = 1'b0;                      step("R5 oe off");
    ab_oe = 1'b1;                      step("R5 oe on");
    // R6: B-to-A path, own controls
    ba_le = 1'b1; b_din = 18'h2AAAA;   step("R6 follow");
    b_din = 18'h00000;                 step("R1 zeros");
    ba_le = 1'b0; b_din = 18'h31313;   step("R6 hold");
    ab_cp = 1'b1; b_din = 18'h0ABCD;   step("R6 ignores ab_cp");
    ba_cp = 1'b1;                      step("R6 capture");
    ba_cp = 1'b0; b_din = 18'h3FFFF;   step("R6 falling edge");
    ab_cp = 1'b0;                      step("R6 hold");
    // R7: B-to-A enable is active low
    ba_oe_n = 1'b1;                    step("R7 oe off");
    ba_oe_n = 1'b0;                    step("R7 oe on");
    // R8: keeper with partial and empty valid masks
    ab_le = 1'b1; a_din = 18'h3FFFF; a_din_vld = ONES;  step("R8 drive");
    a_din = 18'h00000; a_din_vld = 18'h000FF;           step("R8 partial");
    a_din = 18'h15A5A; a_din_vld = '0;                  step("R8 floating");
    ba_le = 1'b1; b_din = 18'h2D2D2; b_din_vld = 18'h3F000; step("R8 b partial");
    // R9 / R10: mid-run reset
    do_reset();
    a_din_vld = ONES; b_din_vld = ONES;
    ab_le = 1'b1; ba_le = 1'b1; a_din = 18'h1E1E1; b_din = 18'h21212;
    step("R2 after reset");
    a_din_vld = '0; b_din_vld = '0;  step("R8 after reset");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule